// File: doc/BRIEF.md
# Three-Requester Memory Access Arbiter With Post-DMA Reordering

This block decides which of three agents may next use a shared cache and memory controller: the I/O subsystem's DMA engine, the memory refresh timer, and the processor. Each agent holds a level request. The arbiter returns at most one grant, and that grant stays high until the controller signals that the transaction has ended. Requests are only considered while no grant is outstanding. The grant appears on the clock edge after the edge at which the requests were sampled.

The normal ranking puts DMA first, refresh second and the processor third. If continuous DMA traffic were ranked that way forever, refresh and the processor would never be served. To prevent this, the first arbitration cycle after a DMA transaction ends uses a rotated ranking: refresh first, processor second, DMA last. After that single cycle the normal ranking returns, whether or not anything was granted in that cycle. There is no data path: every pin is a plain control level, so no valid/ready back-pressure applies.

Top module: `mem_arb3`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and in the first cycle after it is released, all three grant outputs are low.
- R2: At most one of `dma_gnt`, `rfsh_gnt`, `cpu_gnt` is high in any cycle.
- R3: A grant rises only one clock edge after an edge where no grant was outstanding and the matching request was high at that edge.
- R4: In normal ranking, an idle arbitration cycle grants DMA if it requests, otherwise refresh if it requests, otherwise the processor.
- R5: A grant stays high, whatever the requests do, until `xfer_done` is sampled high. `xfer_done` while no grant is outstanding is ignored.
- R6: On the edge where `xfer_done` is sampled high with a grant outstanding, the grant drops. The following edge is an arbitration edge.
- R7: In the first arbitration cycle after a DMA transaction ends, refresh is granted over the processor, and the processor over DMA. DMA is still granted if it is the only requester.
- R8: The rotated ranking lasts exactly one arbitration cycle. If nothing is requested in that cycle, the next arbitration uses normal ranking.
- R9: After a refresh or processor transaction ends, the next arbitration uses normal ranking.
- R10: With DMA and the processor both requesting continuously, grants alternate DMA, processor, DMA, processor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_req | input | 1 | DMA / I/O subsystem request level |
| rfsh_req | input | 1 | Memory refresh request level |
| cpu_req | input | 1 | Processor request level |
| xfer_done | input | 1 | Controller marks the end of the granted transaction |
| dma_gnt | output | 1 | Grant to DMA |
| rfsh_gnt | output | 1 | Grant to refresh |
| cpu_gnt | output | 1 | Grant to processor |

## Verification
The bench builds the arbiter with its package defaults: three requesters, DMA at index 0, refresh at 1 and the processor at 2, with a two-bit rank field. With these settings the bench can reach every ranking outcome in both orders. It can also drive the transitions between them: a DMA end followed by requesters in every relevant combination, an empty rotated cycle, and a non-DMA end. Each of these can be followed cycle by cycle and compared with a small set of hand-derived expected grants.

// File: rtl/arb3_pkg.sv
package arb3_pkg;
  localparam int NREQ     = 3;
  localparam int IDXW     = $clog2(NREQ);
  localparam int IDX_DMA  = 0;
  localparam int IDX_RFSH = 1;
  localparam int IDX_CPU  = 2;
  localparam int NMODES   = 2;

  // rank lists: rank 0 in the lowest field
  localparam logic [NREQ*IDXW-1:0] RANK_NORMAL =
    {IDXW'(IDX_CPU), IDXW'(IDX_RFSH), IDXW'(IDX_DMA)};
  localparam logic [NREQ*IDXW-1:0] RANK_AFTER_DMA =
    {IDXW'(IDX_DMA), IDXW'(IDX_CPU), IDXW'(IDX_RFSH)};

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} arb_state_e;
endpackage

// File: rtl/arb3_rank_pick.sv
module arb3_rank_pick #(
  parameter int NREQ = 3,
  parameter int IDXW = 2
) (
  input  logic [NREQ-1:0]      req,
  input  logic [NREQ*IDXW-1:0] rank,
  output logic [NREQ-1:0]      pick
);
  logic            taken;
  logic [IDXW-1:0] idx;

  always_comb begin
    pick  = '0;
    taken = 1'b0;
    idx   = '0;
    for (int r = 0; r < NREQ; r++) begin
      idx = rank[r*IDXW +: IDXW];
      if (!taken && req[idx]) begin
        pick[idx] = 1'b1;
        taken     = 1'b1;
      end
    end
  end

  // R2: the picker never offers two winners
  always_comb begin
    a_r2_pick_single: assert ($onehot0(pick));
  end
endmodule

// File: rtl/arb3_hold_fsm.sv
module arb3_hold_fsm
  import arb3_pkg::*;
#(
  parameter int NREQ    = 3,
  parameter int DMA_IDX = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] pick_normal,
  input  logic [NREQ-1:0] pick_after,
  input  logic            xfer_done,
  output logic [NREQ-1:0] gnt,
  output logic            post_dma
);
  arb_state_e      state;
  logic [NREQ-1:0] pick_sel;

  assign pick_sel = post_dma ? pick_after : pick_normal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      gnt      <= '0;
      post_dma <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          post_dma <= 1'b0;
          if (|pick_sel) begin
            gnt   <= pick_sel;
            state <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (xfer_done) begin
            gnt      <= '0;
            state    <= ST_IDLE;
            post_dma <= gnt[DMA_IDX];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: one grant at most
  a_r2_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R5: grant held until done
  a_r5_gnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && !xfer_done) |=> (gnt == $past(gnt)));
  // R6: done releases the grant
  a_r6_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && xfer_done) |=> (gnt == '0));
  // R8: rotated ranking lasts one cycle only
  a_r8_post_single: assert property (@(posedge clk) disable iff (!rst_n)
    post_dma |=> !post_dma);
endmodule

// File: rtl/mem_arb3.sv
module mem_arb3
  import arb3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic rfsh_req,
  input  logic cpu_req,
  input  logic xfer_done,
  output logic dma_gnt,
  output logic rfsh_gnt,
  output logic cpu_gnt
);
  logic [NREQ-1:0]      req_vec;
  logic [NREQ-1:0]      gnt_vec;
  logic [NREQ-1:0]      pick_by_mode [NMODES];
  logic [NREQ*IDXW-1:0] rank_by_mode [NMODES];
  logic                 post_dma;

  always_comb begin
    req_vec           = '0;
    req_vec[IDX_DMA]  = dma_req;
    req_vec[IDX_RFSH] = rfsh_req;
    req_vec[IDX_CPU]  = cpu_req;
  end

  assign rank_by_mode[0] = RANK_NORMAL;
  assign rank_by_mode[1] = RANK_AFTER_DMA;

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    arb3_rank_pick #(.NREQ(NREQ), .IDXW(IDXW)) u_pick (
      .req  (req_vec),
      .rank (rank_by_mode[m]),
      .pick (pick_by_mode[m])
    );
  end

  arb3_hold_fsm #(.NREQ(NREQ), .DMA_IDX(IDX_DMA)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pick_normal (pick_by_mode[0]),
    .pick_after  (pick_by_mode[1]),
    .xfer_done   (xfer_done),
    .gnt         (gnt_vec),
    .post_dma    (post_dma)
  );

  assign dma_gnt  = gnt_vec[IDX_DMA];
  assign rfsh_gnt = gnt_vec[IDX_RFSH];
  assign cpu_gnt  = gnt_vec[IDX_CPU];

  // R3: a grant only rises for a requester seen at an idle edge
  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    a_r3_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_vec[i]) |-> ($past(req_vec[i]) && $past(gnt_vec) == '0));
  end

  // R4: normal ranking
  a_r4_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec == '0 && !post_dma && dma_req) |=> dma_gnt);
  a_r4_rfsh_second: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec == '0 && !post_dma && !dma_req && rfsh_req) |=> rfsh_gnt);
  // R7: rotated ranking
  a_r7_rfsh_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec == '0 && post_dma && rfsh_req) |=> rfsh_gnt);
  a_r7_cpu_over_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vec == '0 && post_dma && !rfsh_req && cpu_req) |=> cpu_gnt);
endmodule

// File: tb/tb_mem_arb3.sv
module tb_mem_arb3;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] G_NONE = 3'b000;
  localparam logic [2:0] G_DMA  = 3'b001;
  localparam logic [2:0] G_RFSH = 3'b010;
  localparam logic [2:0] G_CPU  = 3'b100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_req = 1'b0, rfsh_req = 1'b0, cpu_req = 1'b0, xfer_done = 1'b0;
  logic dma_gnt, rfsh_gnt, cpu_gnt;
  int   total = 0;
  int   bad = 0;
  bit   reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_arb3 dut (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .rfsh_req(rfsh_req),
    .cpu_req(cpu_req), .xfer_done(xfer_done),
    .dma_gnt(dma_gnt), .rfsh_gnt(rfsh_gnt), .cpu_gnt(cpu_gnt)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_req(input logic d, input logic r, input logic c);
    dma_req = d; rfsh_req = r; cpu_req = c;
  endtask

  task automatic expect_gnt(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {cpu_gnt, rfsh_gnt, dma_gnt};
    total++;
    if (act !== exp || !$onehot0(act)) begin
      bad++;
      $display("FAIL %s: grants {cpu,rfsh,dma} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // ends the current transaction; grant must drop (R6)
  task automatic end_xfer();
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    expect_gnt(G_NONE, "R6 release on done");
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  task automatic t_reset();
    set_req(1, 1, 1);
    step(); step();
    expect_gnt(G_NONE, "R1 held in reset");
    set_req(0, 0, 0);
    rst_n = 1'b1;
    step();
    expect_gnt(G_NONE, "R1 after reset");
  endtask

  task automatic t_default_order();
    set_req(1, 1, 1); step();
    expect_gnt(G_DMA, "R4 dma wins all");
    set_req(0, 1, 1); step();
    expect_gnt(G_DMA, "R5 hold after req drop");
    set_req(0, 0, 0); step();
    expect_gnt(G_DMA, "R5 hold with no req");
    end_xfer();
    step();                         // rotated cycle, nothing requested
    set_req(0, 1, 1); step();
    expect_gnt(G_RFSH, "R4 rfsh over cpu");
    set_req(0, 0, 0);
    end_xfer();
    step();
  endtask

  task automatic t_post_reorder();
    set_req(1, 1, 1); step();
    expect_gnt(G_DMA, "R4 dma first");
    end_xfer();
    step();
    expect_gnt(G_RFSH, "R7 rfsh first after dma");
    end_xfer();
    step();
    expect_gnt(G_DMA, "R9 normal after rfsh");
    end_xfer();
    set_req(1, 0, 1); step();
    expect_gnt(G_CPU, "R7 cpu over dma");
    end_xfer();
    step();
    expect_gnt(G_DMA, "R9 normal after cpu");
    end_xfer();
    set_req(1, 0, 0); step();
    expect_gnt(G_DMA, "R7 dma alone still granted");
    set_req(0, 0, 0);
    end_xfer();
    step();
  endtask

  task automatic t_post_expire();
    set_req(1, 0, 0); step();
    expect_gnt(G_DMA, "R4 dma grant");
    set_req(0, 0, 0);
    end_xfer();
    step();
    expect_gnt(G_NONE, "R8 empty rotated cycle");
    set_req(1, 1, 1); step();
    expect_gnt(G_DMA, "R8 normal order resumed");
    set_req(0, 0, 0);
    end_xfer();
    step();
  endtask

  task automatic t_stray_done();
    xfer_done = 1'b1;
    step(); step();
    expect_gnt(G_NONE, "R5 idle done no grant");
    xfer_done = 1'b0;
    set_req(0, 0, 1); step();
    expect_gnt(G_CPU, "R3 cpu grant after idle done");
    step();
    expect_gnt(G_CPU, "R5 cpu held");
    set_req(0, 0, 0);
    end_xfer();
    step();
  endtask

  task automatic t_no_starve();
    set_req(1, 0, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      expect_gnt(G_DMA, "R10 dma turn");
      end_xfer();
      step();
      expect_gnt(G_CPU, "R10 cpu turn");
      end_xfer();
    end
    set_req(0, 0, 0);
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_default_order();
    t_post_reorder();
    t_post_expire();
    t_stray_done();
    t_no_starve();
    report();
    $finish;
  end
endmodule